// File: doc/BRIEF.md
# Weighted Trigger Equation Evaluator

The block reaches a global level-1 trigger decision once per trigger tick. Each input set holds three subsystem summaries: a forward time-of-flight track count, a forward calorimeter energy sum and a barrel calorimeter energy sum. The block forms a weighted sum from three terms. Two are linear products: track count times a track weight, and forward energy times a forward-energy weight. The third is a ratio term: (forward energy + 1) divided by (barrel energy + 1), times a ratio weight. The result of the comparison is one decision bit, which leaves with a valid strobe.

The datapath is fully pipelined and takes a new input set on every clock. The ratio uses unsigned fixed point with 8 fractional bits and comes from a restoring divider that produces one quotient bit per stage. Each path is delay-matched, so every decision leaves a fixed number of cycles after its input. Run-time settings go first into a pending copy. They move into the active copy only on a cycle that carries no input set, so one decision never mixes old and new settings.

Top module: `trig_eq_eval`

## Requirements
- R1: The track term is inTofTracks × active track weight, at full precision.
- R2: The forward-energy term is inFcalE × active forward-energy weight, at full precision.
- R3: The ratio term is floor(floor(((inFcalE+1)·256)/(inBcalE+1)) × active ratio weight / 256). The quotient has 8 fractional bits, and the product is truncated back to an integer.
- R4: outTrig is 1 exactly when the active threshold is greater than or equal to the sum of the three terms.
- R5: The sum saturates at 2^28−1 and never wraps. A threshold of 2^28−1 therefore always yields a trigger.
- R6: outValid goes high exactly 28 cycles after the cycle in which inValid was high, and at no other time.
- R7: An input set is accepted on every cycle, with no gaps required. The decisions come out in input order, one per cycle.
- R8: A cfgLoad pulse stores the four setting inputs as pending. The pending settings become active only after a cycle with inValid low. Input sets presented before that cycle use the old settings.
- R9: When both energies are zero, the ratio is exactly 1.0 (256 in fixed point), so the ratio term equals the ratio weight.
- R10: After reset, outValid and outTrig are 0 and all active settings are zero. outTrig is 0 whenever outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input set present this cycle |
| inTofTracks | input | 16 | Forward time-of-flight track count |
| inFcalE | input | 16 | Forward calorimeter energy sum |
| inBcalE | input | 16 | Barrel calorimeter energy sum |
| cfgLoad | input | 1 | Store setting inputs as pending |
| cfgWTof | input | 12 | Track weight |
| cfgWFcal | input | 12 | Forward-energy weight |
| cfgWRatio | input | 12 | Ratio weight |
| cfgThresh | input | 28 | Decision threshold |
| outValid | output | 1 | Decision strobe |
| outTrig | output | 1 | Trigger decision |

## Verification
The hardest case to reach is a settings change that arrives in the middle of an unbroken input stream. The new values must stay pending until the stream pauses. If they took effect early, part of the stream would be judged with the new threshold. The stimulus loads a new threshold on the second set of a back-to-back burst and only then leaves a gap. It also injects loads at random points in long streams that contain random gaps. Saturation is reached with all-ones inputs and weights, and zero energies are driven directly to exercise the +1 offsets.

// File: rtl/trig_eq_pkg.sv
package trig_eq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadPend;
    logic applyCfg;
    logic finalValid;
  } trig_ctrl_t;
endpackage

// File: rtl/trig_eq_ctrl.sv
module trig_eq_ctrl
  import trig_eq_pkg::*;
#(
  parameter int LAT = 28
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       cfgLoad,
  output trig_ctrl_t strb,
  output logic       outValid
);
  logic [LAT-1:0] validPipe;
  logic           pendFlag;
  logic           applyNow;

  assign applyNow = pendFlag & ~inValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validPipe <= '0;
      pendFlag  <= 1'b0;
    end else begin
      validPipe <= {validPipe[LAT-2:0], inValid};
      if (cfgLoad)       pendFlag <= 1'b1;
      else if (applyNow) pendFlag <= 1'b0;
    end
  end

  always_comb begin
    strb.loadPend   = cfgLoad;
    strb.applyCfg   = applyNow;
    strb.finalValid = validPipe[LAT-2];
  end

  assign outValid = validPipe[LAT-1];
endmodule

// File: rtl/trig_eq_dp.sv
module trig_eq_dp
  import trig_eq_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int WGT_W  = 12,
  parameter int FRAC_W = 8,
  parameter int SUM_W  = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  trig_ctrl_t       strb,
  input  logic [IN_W-1:0]  inTofTracks,
  input  logic [IN_W-1:0]  inFcalE,
  input  logic [IN_W-1:0]  inBcalE,
  input  logic [WGT_W-1:0] cfgWTof,
  input  logic [WGT_W-1:0] cfgWFcal,
  input  logic [WGT_W-1:0] cfgWRatio,
  input  logic [SUM_W-1:0] cfgThresh,
  output logic [WGT_W-1:0] actWTof,
  output logic [WGT_W-1:0] actWFcal,
  output logic [WGT_W-1:0] actWRatio,
  output logic [SUM_W-1:0] actThr,
  output logic             outTrig
);
  localparam int DEN_W  = IN_W + 1;
  localparam int NUM_W  = DEN_W + FRAC_W;
  localparam int QW     = NUM_W;
  localparam int PROD_W = IN_W + WGT_W;
  localparam int RP_W   = QW + WGT_W;
  localparam int T3_W   = RP_W - FRAC_W;
  localparam int SR_W   = T3_W + 1;
  localparam logic [SUM_W-1:0] SUM_MAX = '1;

  // pending and active settings
  logic [WGT_W-1:0] pendWTof, pendWFcal, pendWRatio;
  logic [SUM_W-1:0] pendThr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendWTof <= '0; pendWFcal <= '0; pendWRatio <= '0; pendThr <= '0;
      actWTof  <= '0; actWFcal  <= '0; actWRatio  <= '0; actThr  <= '0;
    end else begin
      if (strb.applyCfg) begin
        actWTof   <= pendWTof;
        actWFcal  <= pendWFcal;
        actWRatio <= pendWRatio;
        actThr    <= pendThr;
      end
      if (strb.loadPend) begin
        pendWTof   <= cfgWTof;
        pendWFcal  <= cfgWFcal;
        pendWRatio <= cfgWRatio;
        pendThr    <= cfgThresh;
      end
    end
  end

  // linear terms, formed at the input
  logic [PROD_W-1:0] termTof, termFcal;
  logic [PROD_W:0]   partRaw;
  logic [SUM_W-1:0]  partSat;
  logic [DEN_W-1:0]  numInt, denInt;

  always_comb begin
    termTof  = PROD_W'(inTofTracks) * PROD_W'(actWTof);
    termFcal = PROD_W'(inFcalE) * PROD_W'(actWFcal);
    partRaw  = {1'b0, termTof} + {1'b0, termFcal};
    partSat  = (partRaw > {{(PROD_W + 1 - SUM_W){1'b0}}, SUM_MAX}) ?
               SUM_MAX : partRaw[SUM_W-1:0];
    numInt   = {1'b0, inFcalE} + DEN_W'(1);
    denInt   = {1'b0, inBcalE} + DEN_W'(1);
  end

  // restoring divider pipeline, one quotient bit per stage
  logic [NUM_W-1:0] numS  [0:QW-1];
  logic [DEN_W-1:0] denS  [0:QW-1];
  logic [DEN_W-1:0] remS  [0:QW-1];
  logic [QW-1:0]    quoS  [0:QW];
  logic [SUM_W-1:0] partS [0:QW];
  logic [WGT_W-1:0] wRS   [0:QW];
  logic [SUM_W-1:0] thrS  [0:QW];

  always_ff @(posedge clk) begin
    numS[0]  <= {numInt, {FRAC_W{1'b0}}};
    denS[0]  <= denInt;
    remS[0]  <= '0;
    quoS[0]  <= '0;
    partS[0] <= partSat;
    wRS[0]   <= actWRatio;
    thrS[0]  <= actThr;
  end

  for (genvar k = 0; k < QW; k++) begin : g_div
    logic [DEN_W:0] trial;
    logic           take;
    assign trial = {remS[k], numS[k][NUM_W-1]};
    assign take  = trial >= {1'b0, denS[k]};

    always_ff @(posedge clk) begin
      quoS[k+1]  <= {quoS[k][QW-2:0], take};
      partS[k+1] <= partS[k];
      wRS[k+1]   <= wRS[k];
      thrS[k+1]  <= thrS[k];
    end

    if (k < QW - 1) begin : g_carry
      logic [DEN_W:0] diff;
      assign diff = trial - {1'b0, denS[k]};
      always_ff @(posedge clk) begin
        numS[k+1] <= numS[k] << 1;
        denS[k+1] <= denS[k];
        remS[k+1] <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      end
    end
  end

  // ratio product, final sum, compare
  logic [RP_W-1:0]  ratioProd;
  logic [T3_W-1:0]  termRatio;
  logic [SR_W-1:0]  sumRaw;
  logic [SUM_W-1:0] sumSat, sumQ, thrQ;

  always_comb begin
    ratioProd = RP_W'(quoS[QW]) * RP_W'(wRS[QW]);
    termRatio = ratioProd[RP_W-1:FRAC_W];
    sumRaw    = {{(SR_W - SUM_W){1'b0}}, partS[QW]} + {1'b0, termRatio};
    sumSat    = (sumRaw > {{(SR_W - SUM_W){1'b0}}, SUM_MAX}) ?
                SUM_MAX : sumRaw[SUM_W-1:0];
  end

  always_ff @(posedge clk) begin
    sumQ <= sumSat;
    thrQ <= thrS[QW];
    if (!rstN) outTrig <= 1'b0;
    else       outTrig <= strb.finalValid & (thrQ >= sumQ);
  end
endmodule

// File: rtl/trig_eq_eval.sv
module trig_eq_eval
  import trig_eq_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int WGT_W  = 12,
  parameter int FRAC_W = 8,
  parameter int SUM_W  = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inTofTracks,
  input  logic [IN_W-1:0]  inFcalE,
  input  logic [IN_W-1:0]  inBcalE,
  input  logic             cfgLoad,
  input  logic [WGT_W-1:0] cfgWTof,
  input  logic [WGT_W-1:0] cfgWFcal,
  input  logic [WGT_W-1:0] cfgWRatio,
  input  logic [SUM_W-1:0] cfgThresh,
  output logic             outValid,
  output logic             outTrig
);
  // divider stages + input stage + sum stage + compare stage
  localparam int LAT = IN_W + 1 + FRAC_W + 3;

  trig_ctrl_t       strb;
  logic [WGT_W-1:0] actWTof, actWFcal, actWRatio;
  logic [SUM_W-1:0] actThr;

  trig_eq_ctrl #(.LAT(LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cfgLoad(cfgLoad),
    .strb(strb), .outValid(outValid)
  );

  trig_eq_dp #(.IN_W(IN_W), .WGT_W(WGT_W), .FRAC_W(FRAC_W), .SUM_W(SUM_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inTofTracks(inTofTracks), .inFcalE(inFcalE), .inBcalE(inBcalE),
    .cfgWTof(cfgWTof), .cfgWFcal(cfgWFcal), .cfgWRatio(cfgWRatio),
    .cfgThresh(cfgThresh),
    .actWTof(actWTof), .actWFcal(actWFcal), .actWRatio(actWRatio),
    .actThr(actThr), .outTrig(outTrig)
  );
endmodule

// File: rtl/trig_eq_chk.sv
module trig_eq_chk #(
  parameter int LAT   = 28,
  parameter int WGT_W = 12,
  parameter int SUM_W = 28
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic             outTrig,
  input logic [WGT_W-1:0] actWTof,
  input logic [WGT_W-1:0] actWFcal,
  input logic [WGT_W-1:0] actWRatio,
  input logic [SUM_W-1:0] actThr
);
  // sets accepted but not yet delivered
  logic [15:0] inFlight;
  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= '0;
    else       inFlight <= inFlight + 16'(inValid) - 16'(outValid);
  end

  p_trig_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !outTrig);

  p_no_orphan_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inFlight != 16'd0);

  p_inflight_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= 16'(LAT));

  p_cfg_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ($stable(actWTof) && $stable(actWFcal) &&
                 $stable(actWRatio) && $stable(actThr)));
endmodule

bind trig_eq_eval trig_eq_chk #(.LAT(LAT), .WGT_W(WGT_W), .SUM_W(SUM_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outTrig(outTrig), .actWTof(actWTof), .actWFcal(actWFcal),
  .actWRatio(actWRatio), .actThr(actThr)
);

// File: tb/tb_trig_eq_eval.sv
module tb_trig_eq_eval;
  localparam int    LAT     = 28;
  localparam longint SUM_MAX = (64'd1 << 28) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inTofTracks = '0, inFcalE = '0, inBcalE = '0;
  logic        cfgLoad = 1'b0;
  logic [11:0] cfgWTof = '0, cfgWFcal = '0, cfgWRatio = '0;
  logic [27:0] cfgThresh = '0;
  logic        outValid, outTrig;

  always #5 clk = ~clk;

  trig_eq_eval dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inTofTracks(inTofTracks), .inFcalE(inFcalE), .inBcalE(inBcalE),
    .cfgLoad(cfgLoad), .cfgWTof(cfgWTof), .cfgWFcal(cfgWFcal),
    .cfgWRatio(cfgWRatio), .cfgThresh(cfgThresh),
    .outValid(outValid), .outTrig(outTrig)
  );

  int nChk = 0, nErr = 0, cyc = 0;
  int    dueQ[$];
  bit    expQ[$];
  string tagQ[$];

  // settings model
  longint aT = 0, aF = 0, aR = 0, aZ = 0;
  longint pT = 0, pF = 0, pR = 0, pZ = 0;
  bit     pend = 0;

  function automatic bit refTrig(longint tof, longint fe, longint be,
                                 longint wT, longint wF, longint wR, longint z);
    longint q, s;
    q = ((fe + 1) << 8) / (be + 1);
    s = tof * wT + fe * wF + ((q * wR) >> 8);
    if (s > SUM_MAX) s = SUM_MAX;
    return z >= s;
  endfunction

  task automatic scoreboard();
    if (dueQ.size() > 0 && dueQ[0] == cyc) begin
      nChk++;
      if (outValid !== 1'b1 || outTrig !== expQ[0]) begin
        nErr++;
        $display("FAIL %s: cyc %0d valid=%b trig=%b expected valid=1 trig=%b",
                 tagQ[0], cyc, outValid, outTrig, expQ[0]);
      end
      void'(dueQ.pop_front()); void'(expQ.pop_front()); void'(tagQ.pop_front());
    end else begin
      nChk++;
      if (outValid !== 1'b0 || outTrig !== 1'b0) begin
        nErr++;
        $display("FAIL R6/R10: cyc %0d valid=%b trig=%b expected valid=0 trig=0",
                 cyc, outValid, outTrig);
      end
    end
  endtask

  task automatic step(bit v, int tof, int fe, int be, bit ld,
                      longint wT, longint wF, longint wR, longint z, string tag);
    bit ap;
    @(negedge clk);
    cyc++;
    if (rstN) scoreboard();
    inValid = v; inTofTracks = 16'(tof); inFcalE = 16'(fe); inBcalE = 16'(be);
    cfgLoad = ld; cfgWTof = 12'(wT); cfgWFcal = 12'(wF); cfgWRatio = 12'(wR);
    cfgThresh = 28'(z);
    if (v) begin
      dueQ.push_back(cyc + LAT);
      expQ.push_back(refTrig(tof, fe, be, aT, aF, aR, aZ));
      tagQ.push_back(tag);
    end
    ap = pend && !v;
    if (ap) begin aT = pT; aF = pF; aR = pR; aZ = pZ; end
    if (ld) begin pT = wT; pF = wF; pR = wR; pZ = z; pend = 1; end
    else if (ap) pend = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  task automatic setCfg(longint wT, longint wF, longint wR, longint z);
    step(0, 0, 0, 0, 1, wT, wF, wR, z, "cfg");
    idle(1);
  endtask

  task automatic drain();
    idle(LAT + 2);
  endtask

  initial begin
    #(200000 * 10);
    nErr++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    nChk++;
    if (outValid !== 1'b0 || outTrig !== 1'b0) begin
      nErr++;
      $display("FAIL R10: reset valid=%b trig=%b expected 0 0", outValid, outTrig);
    end
    @(negedge clk); rstN = 1'b1;
    // R10 active settings zero after reset: sum 0, threshold 0 -> trigger
    step(1, 500, 900, 3, 0, 0, 0, 0, 0, "R10 zero settings");
    drain();

    // R1 track term alone
    setCfg(7, 0, 0, 3500);
    step(1, 500, 0, 0, 0, 0, 0, 0, 0, "R1 at threshold");
    step(1, 501, 0, 0, 0, 0, 0, 0, 0, "R1 above threshold");
    // R2 forward-energy term alone
    setCfg(0, 5, 0, 5000);
    step(1, 9, 1000, 77, 0, 0, 0, 0, 0, "R2 equal");
    step(1, 9, 1001, 77, 0, 0, 0, 0, 0, "R2 over");
    // R3 ratio term: (100+1)*256/(9+1)=2585, *200>>8 = 2019
    setCfg(0, 0, 200, 2019);
    step(1, 0, 100, 9, 0, 0, 0, 0, 0, "R3 floor equal");
    setCfg(0, 0, 200, 2018);
    step(1, 0, 100, 9, 0, 0, 0, 0, 0, "R3 floor over");
    // R9 zero energies: ratio exactly 1.0
    setCfg(0, 0, 300, 300);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9 ratio one equal");
    setCfg(0, 0, 300, 299);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9 ratio one over");
    // R4 combined sum
    setCfg(3, 2, 128, 100000);
    step(1, 1000, 40000, 65535, 0, 0, 0, 0, 0, "R4 combined");
    step(1, 0, 0, 65535, 0, 0, 0, 0, 0, "R4 small sum");
    // R5 saturation
    setCfg(4095, 4095, 4095, SUM_MAX);
    step(1, 65535, 65535, 0, 0, 0, 0, 0, 0, "R5 saturated at max");
    setCfg(4095, 4095, 4095, SUM_MAX - 1);
    step(1, 65535, 65535, 0, 0, 0, 0, 0, 0, "R5 saturated below max");
    drain();

    // R8 load mid-stream: old threshold used until a gap
    setCfg(1, 0, 0, 1000);
    step(1, 10, 0, 0, 0, 0, 0, 0, 0, "R8 before load");
    step(1, 10, 0, 0, 1, 1, 0, 0, 5, "R8 load cycle");
    for (int i = 0; i < 5; i++) step(1, 10, 0, 0, 0, 0, 0, 0, 0, "R8 stream old cfg");
    idle(1);
    step(1, 10, 0, 0, 0, 0, 0, 0, 0, "R8 after gap new cfg");
    drain();

    // R7 long back-to-back streams with random loads and gaps
    for (int i = 0; i < 600; i++) begin
      bit v, ld;
      v  = ($urandom % 8) != 0;
      ld = ($urandom % 20) == 0;
      step(v, int'($urandom % 65536), int'($urandom % 65536), int'($urandom % 65536),
           ld, longint'($urandom % 4096), longint'($urandom % 4096),
           longint'($urandom % 4096), longint'($urandom % (1 << 28)), "R7 stream");
    end
    for (int i = 0; i < 300; i++)
      step(1, int'($urandom % 256), int'($urandom % 4096), int'($urandom % 16), 0,
           0, 0, 0, 0, "R7 dense");
    drain();

    nChk++;
    if (dueQ.size() != 0) begin
      nErr++;
      $display("FAIL R6: %0d decisions missing, expected 0", dueQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end
endmodule